// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers interrupt events from three sources (receive, transmit and a miscellaneous group) into 32-bit cause registers that a host reads and clears through a simple word-addressed register port. Each group has a per-bit clear-mode register. A cause bit whose mode bit is 1 is cleared by reading the cause register. A cause bit whose mode bit is 0 is cleared only by writing 1 to it. Each group also has an interrupt mask that is changed through separate set and clear write addresses. Software can raise cause bits itself. Each group offers a read-only masked-cause view and a read-only mask readback.

A summary register holds one bit per group. A summary bit is set whenever its group has any cause bit that is not masked, and it clears when the summary register is read. A software mask on the summary register gates the single level-sensitive interrupt output. Event inputs are single-cycle pulses, one bit per cause bit.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every mask bit reads 1, every cause bit reads 0, the summary reads 0, the summary mask reads 7 and `irq_o` is low.
- R2: A pulse on event input bit g*32+i sets cause bit i of group g (RX=0, TX=1, MISC=2) from the next cycle on.
- R3: Register address is {group[1:0], offset[2:0]}. A read of offset 0 (cause) returns the cause value one cycle later with `rd_valid_o` high. Cause bits whose clear-mode bit is 1 are then cleared, and bits whose mode bit is 0 are kept.
- R4: Writing to offset 0 clears the cause bits that are written as 1 and have clear-mode bit 0. All other bits are unchanged.
- R5: Offset 1 is the read/write clear-mode register. Writing offset 2 sets the mask bits written as 1. Writing offset 3 clears the mask bits written as 1. Offset 6 reads the mask. Offsets 2, 3 and 4 read as 0.
- R6: Writing offset 4 sets the cause bits written as 1.
- R7: Offset 5 reads cause AND NOT mask, with no side effect.
- R8: Address 24 reads the summary: bit g is set in the cycle after group g has an unmasked cause bit. A read clears it, unless the group is still active.
- R9: Address 25 is the 3-bit summary mask, which reads back zero-extended. `irq_o` is high exactly when a summary bit is set whose summary mask bit is 0.
- R10: When an event and a clearing access hit the same cause bit in one cycle, the bit stays set.
- R11: The MISC clear-mode register resets to 0xF7FFFFFF, with bit 27 as write-1-to-clear. The RX and TX clear-mode registers reset to 0.
- R12: Addresses 7, 15, 23 and 26 to 31 read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 96 | Event pulses, 32 per group, RX in the low bits |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Word address |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt output |

## Verification
Two things can happen to one cause bit in the same cycle: a hardware event pulse, and a host access that clears it (a read in clear-on-read mode, or a write of 1 in write-1-to-clear mode). The bench provokes this by pulsing an event in the same cycle as the clearing access, on purpose in directed steps and often in the random run. It then checks by a later read that the bit survived. A summary read that falls in the same cycle as a group still being active is judged the same way: the summary bit must stay set.

// File: rtl/icb_pkg.sv
package icb_pkg;

    // Register offsets inside one group window
    typedef enum logic [2:0] {
        OFF_CAUSE = 3'd0,
        OFF_MODE  = 3'd1,
        OFF_MSET  = 3'd2,
        OFF_MCLR  = 3'd3,
        OFF_CSET  = 3'd4,
        OFF_MVIEW = 3'd5,
        OFF_MVAL  = 3'd6,
        OFF_NONE  = 3'd7
    } reg_off_e;

    // Offsets inside the summary window (group index == number of groups)
    localparam logic [2:0] SUM_OFF_STAT = 3'd0;
    localparam logic [2:0] SUM_OFF_MASK = 3'd1;

    localparam int GRP_RX   = 0;
    localparam int GRP_TX   = 1;
    localparam int GRP_MISC = 2;

endpackage

// File: rtl/icb_decode.sv
module icb_decode
    import icb_pkg::*;
#(
    parameter int NGRP   = 3,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = SEL_W + 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NGRP-1:0]   grp_hit_o,
    output logic              sum_hit_o,
    output reg_off_e          off_o
);

    logic [SEL_W-1:0] sel;

    always_comb begin
        sel   = addr_i[ADDR_W-1:3];
        off_o = reg_off_e'(addr_i[2:0]);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_hit
        assign grp_hit_o[g] = (sel == SEL_W'(g));
    end

    assign sum_hit_o = (sel == SEL_W'(NGRP));

endmodule

// File: rtl/icb_group.sv
module icb_group
    import icb_pkg::*;
#(
    parameter int         W        = 32,
    parameter logic [W-1:0] MODE_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         hit_i,
    input  logic         req_valid_i,
    input  logic         req_write_i,
    input  reg_off_e     off_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] rdata_o,
    output logic         active_o
);

    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] mask;
        logic [W-1:0] mode;
    } grp_st_t;

    grp_st_t st_d, st_q;

    logic         rd_acc;
    logic         wr_acc;
    logic [W-1:0] clr_bits;
    logic [W-1:0] set_bits;

    always_comb begin
        st_d     = st_q;
        rd_acc   = hit_i && req_valid_i && !req_write_i;
        wr_acc   = hit_i && req_valid_i && req_write_i;
        clr_bits = '0;
        set_bits = ev_i;

        if (rd_acc && off_i == OFF_CAUSE) begin
            clr_bits = st_q.mode;
        end
        if (wr_acc) begin
            unique case (off_i)
                OFF_CAUSE: clr_bits   = wdata_i & ~st_q.mode;
                OFF_MODE:  st_d.mode  = wdata_i;
                OFF_MSET:  st_d.mask  = st_q.mask | wdata_i;
                OFF_MCLR:  st_d.mask  = st_q.mask & ~wdata_i;
                OFF_CSET:  set_bits   = ev_i | wdata_i;
                default:   ;
            endcase
        end

        // events and software sets win over any clear in the same cycle
        st_d.cause = (st_q.cause & ~clr_bits) | set_bits;

        unique case (off_i)
            OFF_CAUSE: rdata_o = st_q.cause;
            OFF_MODE:  rdata_o = st_q.mode;
            OFF_MVIEW: rdata_o = st_q.cause & ~st_q.mask;
            OFF_MVAL:  rdata_o = st_q.mask;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cause <= '0;
            st_q.mask  <= '1;
            st_q.mode  <= MODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o  = st_q.cause;
    assign mask_o   = st_q.mask;
    assign active_o = |(st_q.cause & ~st_q.mask);

endmodule

// File: rtl/icb_summary.sv
module icb_summary #(
    parameter int NGRP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] active_i,
    input  logic            rd_clr_i,
    input  logic            wr_mask_i,
    input  logic [NGRP-1:0] wmask_i,
    output logic [NGRP-1:0] sum_o,
    output logic [NGRP-1:0] smask_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [NGRP-1:0] sum;
        logic [NGRP-1:0] smask;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // an active group keeps its bit set even across a clearing read
        st_d.sum = (st_q.sum & ~{NGRP{rd_clr_i}}) | active_i;
        if (wr_mask_i) begin
            st_d.smask = wmask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sum   <= '0;
            st_q.smask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o   = st_q.sum;
    assign smask_o = st_q.smask;
    assign irq_o   = |(st_q.sum & ~st_q.smask);

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import icb_pkg::*;
#(
    parameter int  NGRP     = 3,
    parameter int  W        = 32,
    parameter logic [NGRP*W-1:0] MODE_RST = {32'hF7FF_FFFF, 32'h0, 32'h0},
    localparam int SEL_W    = $clog2(NGRP + 1),
    localparam int ADDR_W   = SEL_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NGRP*W-1:0] ev_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [W-1:0]      req_wdata_i,
    output logic              rd_valid_o,
    output logic [W-1:0]      rd_data_o,
    output logic              irq_o
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    logic [NGRP-1:0]   grp_hit;
    logic              sum_hit;
    reg_off_e          off;
    logic [W-1:0]      grp_rdata [NGRP];
    logic [NGRP-1:0]   grp_active;
    logic [NGRP*W-1:0] cause_flat;
    logic [NGRP*W-1:0] mask_flat;
    logic [NGRP-1:0]   sum_q;
    logic [NGRP-1:0]   smask_q;
    logic              sum_rd_clr;
    logic              sum_wr_mask;

    icb_decode #(
        .NGRP   (NGRP),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr_i    (req_addr_i),
        .grp_hit_o (grp_hit),
        .sum_hit_o (sum_hit),
        .off_o     (off)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        icb_group #(
            .W        (W),
            .MODE_RST (MODE_RST[g*W +: W])
        ) u_grp (
            .clk         (clk),
            .rst_n       (rst_n),
            .ev_i        (ev_i[g*W +: W]),
            .hit_i       (grp_hit[g]),
            .req_valid_i (req_valid_i),
            .req_write_i (req_write_i),
            .off_i       (off),
            .wdata_i     (req_wdata_i),
            .cause_o     (cause_flat[g*W +: W]),
            .mask_o      (mask_flat[g*W +: W]),
            .rdata_o     (grp_rdata[g]),
            .active_o    (grp_active[g])
        );
    end

    assign sum_rd_clr  = req_valid_i && !req_write_i && sum_hit && off == reg_off_e'(SUM_OFF_STAT);
    assign sum_wr_mask = req_valid_i && req_write_i && sum_hit && off == reg_off_e'(SUM_OFF_MASK);

    icb_summary #(
        .NGRP (NGRP)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (grp_active),
        .rd_clr_i  (sum_rd_clr),
        .wr_mask_i (sum_wr_mask),
        .wmask_i   (req_wdata_i[NGRP-1:0]),
        .sum_o     (sum_q),
        .smask_o   (smask_q),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_d       = '0;
        rd_d.valid = req_valid_i && !req_write_i;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_hit[g]) begin
                rd_d.data = rd_d.data | grp_rdata[g];
            end
        end
        if (sum_hit && off == reg_off_e'(SUM_OFF_STAT)) begin
            rd_d.data = W'(sum_q);
        end else if (sum_hit && off == reg_off_e'(SUM_OFF_MASK)) begin
            rd_d.data = W'(smask_q);
        end
        if (!rd_d.valid) begin
            rd_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_data_o  = rd_q.data;

endmodule

// File: rtl/icb_checker.sv
module icb_checker
    import icb_pkg::*;
#(
    parameter int NGRP   = 3,
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NGRP*W-1:0] ev_i,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [W-1:0]      req_wdata_i,
    input logic              rd_valid_o,
    input logic              irq_o,
    input logic [NGRP*W-1:0] cause_all,
    input logic [NGRP*W-1:0] mask_all,
    input logic [NGRP-1:0]   sum_all,
    input logic [NGRP-1:0]   smask_all
);

    // R2 / R10: an event bit is set next cycle whatever access happened
    a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((cause_all & $past(ev_i)) == $past(ev_i)));

    // R3: every read request gets a valid strobe one cycle later
    a_r3_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rd_valid_o);

    // R9: fully masked summary never raises the output
    a_r9_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (&smask_all) |-> !irq_o);

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(g * 8);

        // R5: mask set write
        a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_i && req_write_i && req_addr_i == (BASE | ADDR_W'(OFF_MSET)))
            |=> ((mask_all[g*W +: W] & $past(req_wdata_i)) == $past(req_wdata_i)));

        // R5: mask clear write
        a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_i && req_write_i && req_addr_i == (BASE | ADDR_W'(OFF_MCLR)))
            |=> ((mask_all[g*W +: W] & $past(req_wdata_i)) == '0));

        // R6: software cause set
        a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_i && req_write_i && req_addr_i == (BASE | ADDR_W'(OFF_CSET)))
            |=> ((cause_all[g*W +: W] & $past(req_wdata_i)) == $past(req_wdata_i)));

        // R8: unmasked activity shows in the summary next cycle
        a_r8_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
            ((cause_all[g*W +: W] & ~mask_all[g*W +: W]) != '0) |=> sum_all[g]);
    end

endmodule

bind irq_cause_bank icb_checker #(
    .NGRP   (NGRP),
    .W      (W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rd_valid_o  (rd_valid_o),
    .irq_o       (irq_o),
    .cause_all   (cause_flat),
    .mask_all    (mask_flat),
    .sum_all     (sum_q),
    .smask_all   (smask_q)
);

// File: tb/irq_cause_bank_tb.sv
`timescale 1ns/1ps
module irq_cause_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] ev = '0;
    logic        rv = 1'b0;
    logic        rw = 1'b0;
    logic [4:0]  ra = '0;
    logic [31:0] rd_w = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_cause [3];
    logic [31:0] m_mask  [3];
    logic [31:0] m_mode  [3];
    logic [2:0]  m_sum;
    logic [2:0]  m_smask;

    always #10 clk = ~clk;

    irq_cause_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .req_valid_i (rv),
        .req_write_i (rw),
        .req_addr_i  (ra),
        .req_wdata_i (rd_w),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .irq_o       (irq)
    );

    function automatic void m_reset();
        for (int g = 0; g < 3; g++) begin
            m_cause[g] = '0;
            m_mask[g]  = '1;
            m_mode[g]  = '0;
        end
        m_mode[2] = 32'hF7FF_FFFF;
        m_sum     = '0;
        m_smask   = '1;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        int g = int'(a[4:3]);
        if (g == 3) begin
            if (a[2:0] == 3'd0) return {29'd0, m_sum};
            if (a[2:0] == 3'd1) return {29'd0, m_smask};
            return '0;
        end
        case (a[2:0])
            3'd0: return m_cause[g];
            3'd1: return m_mode[g];
            3'd5: return m_cause[g] & ~m_mask[g];
            3'd6: return m_mask[g];
            default: return '0;
        endcase
    endfunction

    function automatic void m_step(input bit v, input bit w, input logic [4:0] a,
                                   input logic [31:0] d, input logic [95:0] e);
        logic [2:0] act;
        for (int g = 0; g < 3; g++) act[g] = |(m_cause[g] & ~m_mask[g]);
        for (int g = 0; g < 3; g++) begin
            logic [31:0] clr = '0;
            logic [31:0] set = e[g*32 +: 32];
            bit hit = v && (int'(a[4:3]) == g);
            if (hit && !w && a[2:0] == 3'd0) clr = m_mode[g];
            if (hit && w) begin
                case (a[2:0])
                    3'd0: clr = d & ~m_mode[g];
                    3'd1: m_mode[g] = d;
                    3'd2: m_mask[g] = m_mask[g] | d;
                    3'd3: m_mask[g] = m_mask[g] & ~d;
                    3'd4: set = set | d;
                    default: ;
                endcase
            end
            m_cause[g] = (m_cause[g] & ~clr) | set;
        end
        if (v && !w && a == 5'd24) m_sum = '0;
        m_sum = m_sum | act;
        if (v && w && a == 5'd25) m_smask = d[2:0];
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a[4:3] == 2'd3) return (a[2:0] == 3'd0) ? "R8" : (a[2:0] == 3'd1) ? "R9" : "R12";
        case (a[2:0])
            3'd0: return "R3";
            3'd1: return "R5";
            3'd5: return "R7";
            3'd6: return "R5";
            3'd7: return "R12";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; call at a negative edge
    task automatic op(input bit v, input bit w, input logic [4:0] a,
                      input logic [31:0] d, input logic [95:0] e, input string tag);
        logic [31:0] exp_rd;
        bit exp_rv;
        string t;
        rv = v; rw = w; ra = a; rd_w = d; ev = e;
        exp_rv = v && !w;
        exp_rd = exp_rv ? m_read(a) : 32'd0;
        t = (tag == "") ? tag_of(a) : tag;
        m_step(v, w, a, d, e);
        @(negedge clk);
        rv = 1'b0; rw = 1'b0; ev = '0;
        check(t, {31'd0, rd_valid}, {31'd0, exp_rv});
        if (exp_rv) check(t, rd_data, exp_rd);
        check((tag == "") ? "R9" : tag, {31'd0, irq}, {31'd0, |(m_sum & ~m_smask)});
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        op(1'b1, 1'b0, a, 32'd0, '0, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        op(1'b1, 1'b1, a, d, '0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11 reset state
        for (int g = 0; g < 3; g++) begin
            rd(5'(g * 8 + 6), "R1");
            rd(5'(g * 8 + 0), "R1");
            rd(5'(g * 8 + 1), "R11");
        end
        rd(5'd24, "R1");
        rd(5'd25, "R1");

        // R2 / R3: RX with low half clear-on-read
        wr(5'd1, 32'h0000_FFFF, "R5");
        op(1'b0, 1'b0, 5'd0, 32'd0, 96'h0010_0001, "R2");
        rd(5'd0, "R3");
        rd(5'd0, "R3");
        // R4: write 1 clears only the write-1-to-clear bit
        wr(5'd0, 32'h0010_0001, "R4");
        rd(5'd0, "R4");
        // R10: event and write-1 clear on the same bit
        op(1'b0, 1'b0, 5'd0, 32'd0, 96'h0020_0000, "R2");
        op(1'b1, 1'b1, 5'd0, 32'h0020_0000, 96'h0020_0000, "R10");
        rd(5'd0, "R10");
        // R10: event and clear-on-read on the same bit
        op(1'b0, 1'b0, 5'd0, 32'd0, 96'h0000_0004, "R2");
        op(1'b1, 1'b0, 5'd0, 32'd0, 96'h0000_0004, "R10");
        rd(5'd0, "R10");
        // R6 / R7 / R5 on TX
        wr(5'd12, 32'hA5A5_0000, "R6");
        wr(5'd11, 32'h00FF_FF00, "R5");
        rd(5'd13, "R7");
        rd(5'd14, "R5");
        wr(5'd10, 32'h0000_FF00, "R5");
        rd(5'd14, "R5");
        // R8 / R9: summary and output
        rd(5'd24, "R8");
        rd(5'd24, "R8");
        wr(5'd25, 32'h0000_0000, "R9");
        op(1'b0, 1'b0, 5'd0, 32'd0, '0, "R9");
        wr(5'd25, 32'hFFFF_FFFF, "R9");
        rd(5'd25, "R9");
        // MISC bit 27 needs a write to clear
        op(1'b0, 1'b0, 5'd0, 32'd0, {32'h0800_0010, 64'd0}, "R2");
        rd(5'd16, "R11");
        rd(5'd16, "R11");
        wr(5'd16, 32'h0800_0000, "R11");
        rd(5'd16, "R11");
        // R12 unmapped
        wr(5'd7, 32'hFFFF_FFFF, "R12");
        wr(5'd30, 32'hFFFF_FFFF, "R12");
        rd(5'd7, "R12");
        rd(5'd30, "R12");
        rd(5'd14, "R12");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [95:0] e;
            logic [4:0]  a;
            logic [31:0] d;
            int kind = int'($urandom % 8);
            for (int g = 0; g < 3; g++) e[g*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
            if ($urandom % 3 == 0) e = '0;
            a = 5'($urandom % 32);
            d = $urandom & $urandom;
            if (kind == 0) d = $urandom;
            if (kind == 1) a = 5'd24;
            if (kind == 2) d = {29'd0, 3'($urandom)};
            op(kind != 7, ($urandom % 2) == 1, a, d, e, "");
        end
        for (int a = 0; a < 32; a++) rd(5'(a), "");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule